// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Routing

This block is a general purpose I/O peripheral with up to 32 lines, set by a parameter. Software reaches it through a single-cycle register port with 32-bit data. It holds an output value, a direction per line, and interrupt controls for each line. Every input pin passes through a two-stage synchroniser before it is used.

Each line can raise an interrupt on a level or an edge. Two bits per line select the trigger: a polarity bit and an edge bit. A per-line enable gates the interrupt. An 8-bit route field then sends it to one of several shared interrupt wires, or to none. Several lines may drive the same wire, which is the OR of all of them.

Typical use: software sets the route field, the polarity and the edge selection first, and then sets the enable bit. It samples the pins through the input register.

Top module: `gpio_route_ctrl`

## Requirements
- R1: After reset, every line register reads zero, every route field reads 0xFF, `pin_oe` is zero, `pin_out` is zero and `irq_out` is zero.
- R2: A read presented in one cycle returns its data on `bus_rdata` in the next cycle. In a cycle that follows no read, `bus_rdata` is zero. Offsets that map to no register, and offsets that are not word-aligned, read as zero.
- R3: The word addresses are fixed. Pin input is at 0x00 and is read-only. Output value is at 0x04, direction at 0x08, enable at 0x0C, polarity at 0x10, edge selection at 0x14 and spare storage at 0x18. Route words start at 0x20, one word for every four lines: line 4k+j sits in bits [8j+7:8j] of the word at 0x20+4k. Bit n of each line register belongs to line n. The spare register is read/write and has no effect on any pin or interrupt.
- R4: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the output register ANDed with the direction register.
- R5: A value on `pin_in` appears in the pin input register after two clock edges. A read presented together with the pin change, or one cycle after it, returns the old value. A read one cycle later than that returns the new value.
- R6: The trigger encoding is {edge, polarity}. 00 means level-low and 01 means level-high; for these two the line triggers for as long as the synchronised level holds.
- R7: Encoding 11 is rising edge and 10 is falling edge. Either one gives a trigger for exactly one cycle: the cycle after the second synchroniser stage takes the new value.
- R8: A line whose enable bit is 0 never drives an interrupt wire. Clearing the bit removes its contribution in the cycle right after the write edge, even when a trigger starts at that same edge.
- R9: A route field value v below NOUT sends the line to `irq_out[v]`. The value 0xFF, or any value of NOUT or more, routes the line nowhere.
- R10: Each `irq_out` wire is the OR of the triggers of all enabled lines routed to it.
- R11: For lines at or above NLINES, register bits and route fields read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pin_in | input | NLINES | Raw pin levels |
| pin_out | output | NLINES | Output value for driven lines |
| pin_oe | output | NLINES | Output enable per line |
| irq_out | output | NOUT | Shared interrupt wires |

## Verification
A register write that clears a line's enable bit can land on the same clock edge at which that line's rising edge reaches the second synchroniser stage. The bench sets a pin high, waits one edge, and then issues the enable-clear write, so that the write edge and the detection edge coincide. The wire must stay low in that cycle and in the next one. A second overlap is also covered: two lines on one wire swap levels in the same cycle, and the wire must stay high without a gap.

// File: rtl/gpio_route_pkg.sv
// Package: shared offsets, field constants and trigger encoding for the
// GPIO routing controller. Assumes byte addressing with 32-bit words.
package gpio_route_pkg;
    localparam int OFF_DATA   = 'h00;
    localparam int OFF_OUT    = 'h04;
    localparam int OFF_DIR    = 'h08;
    localparam int OFF_MASK   = 'h0C;
    localparam int OFF_POL    = 'h10;
    localparam int OFF_EDGE   = 'h14;
    localparam int OFF_SPARE  = 'h18;
    localparam int OFF_ROUTE  = 'h20;

    localparam logic [7:0] ROUTE_NONE = 8'hFF;

    // Trigger encoding: {edge select, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LOW  = 2'b00,
        TRIG_LVL_HIGH = 2'b01,
        TRIG_FALL     = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop input synchroniser that also keeps the previous
// synchronised sample for edge detection. Assumes a synchronous active-low reset.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta_q;

    // Shift the raw pins through two stages, then one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/gpio_trigger.sv
// Module: per-line trigger detector. It decodes the {edge, polarity} pair
// into level-low, level-high, falling or rising. Purely combinational;
// the inputs are assumed to be already synchronised.
module gpio_trigger
    import gpio_route_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] polar,
    input  logic [W-1:0] edgesel,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_line
        // Select the trigger condition for this line
        always_comb begin
            case (trig_e'({edgesel[i], polar[i]}))
                TRIG_LVL_LOW:  hit[i] = ~lvl[i];
                TRIG_LVL_HIGH: hit[i] = lvl[i];
                TRIG_FALL:     hit[i] = ~lvl[i] & lvl_prev[i];
                default:       hit[i] = lvl[i] & ~lvl_prev[i];
            endcase
        end
    end
endmodule

// File: rtl/gpio_router.sv
// Module: gates each line trigger with its enable bit and ORs it onto the
// interrupt wire chosen by its 8-bit route field. Field values of NOUT or
// more match no wire. Assumes NOUT <= 255.
module gpio_router #(
    parameter int NLINES = 32,
    parameter int NOUT   = 4
) (
    input  logic [NLINES-1:0]   hit,
    input  logic [NLINES-1:0]   enable,
    input  logic [NLINES*8-1:0] route,
    output logic [NOUT-1:0]     irq
);
    // Merge all enabled, routed triggers onto their wires
    always_comb begin
        irq = '0;
        for (int o = 0; o < NOUT; o++) begin
            for (int i = 0; i < NLINES; i++) begin
                if (hit[i] && enable[i] && (route[8*i +: 8] == 8'(o)))
                    irq[o] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: register file and single-cycle bus port. Writes take effect at
// the clock edge. Reads are registered, so data is valid the next cycle.
// Unmapped or misaligned offsets read zero. Bits of lines >= NLINES are
// not stored.
module gpio_regs
    import gpio_route_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NLINES-1:0]   pin_lvl,
    output logic [NLINES-1:0]   out_q,
    output logic [NLINES-1:0]   dir_q,
    output logic [NLINES-1:0]   mask_q,
    output logic [NLINES-1:0]   pol_q,
    output logic [NLINES-1:0]   edge_q,
    output logic [NLINES*8-1:0] route_flat
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_DATA  = WORD_W'(OFF_DATA  / 4);
    localparam logic [WORD_W-1:0] W_OUT   = WORD_W'(OFF_OUT   / 4);
    localparam logic [WORD_W-1:0] W_DIR   = WORD_W'(OFF_DIR   / 4);
    localparam logic [WORD_W-1:0] W_MASK  = WORD_W'(OFF_MASK  / 4);
    localparam logic [WORD_W-1:0] W_POL   = WORD_W'(OFF_POL   / 4);
    localparam logic [WORD_W-1:0] W_EDGE  = WORD_W'(OFF_EDGE  / 4);
    localparam logic [WORD_W-1:0] W_SPARE = WORD_W'(OFF_SPARE / 4);
    localparam int                W_ROUTE = OFF_ROUTE / 4;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              do_wr;
    logic              do_rd;
    logic [NLINES-1:0] spare_q;
    logic [7:0]        route_q [NLINES];
    logic [31:0]       rd_val;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign do_wr   = bus_en && bus_wr && aligned;
    assign do_rd   = bus_en && !bus_wr;

    // Update the line registers on an aligned write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            mask_q  <= '0;
            pol_q   <= '0;
            edge_q  <= '0;
            spare_q <= '0;
        end else if (do_wr) begin
            if (word == W_OUT)   out_q   <= bus_wdata[NLINES-1:0];
            if (word == W_DIR)   dir_q   <= bus_wdata[NLINES-1:0];
            if (word == W_MASK)  mask_q  <= bus_wdata[NLINES-1:0];
            if (word == W_POL)   pol_q   <= bus_wdata[NLINES-1:0];
            if (word == W_EDGE)  edge_q  <= bus_wdata[NLINES-1:0];
            if (word == W_SPARE) spare_q <= bus_wdata[NLINES-1:0];
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_route
        localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(W_ROUTE + i / 4);
        localparam int                LANE    = 8 * (i % 4);
        // Hold the route field of this line; unrouted after reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[i] <= ROUTE_NONE;
            else if (do_wr && word == MY_WORD)
                route_q[i] <= bus_wdata[LANE +: 8];
        end
        assign route_flat[8*i +: 8] = route_q[i];
    end

    // Select the read value for the addressed word
    always_comb begin
        rd_val = '0;
        if (aligned) begin
            case (word)
                W_DATA:  rd_val[NLINES-1:0] = pin_lvl;
                W_OUT:   rd_val[NLINES-1:0] = out_q;
                W_DIR:   rd_val[NLINES-1:0] = dir_q;
                W_MASK:  rd_val[NLINES-1:0] = mask_q;
                W_POL:   rd_val[NLINES-1:0] = pol_q;
                W_EDGE:  rd_val[NLINES-1:0] = edge_q;
                W_SPARE: rd_val[NLINES-1:0] = spare_q;
                default: begin
                    for (int i = 0; i < NLINES; i++) begin
                        if (word == WORD_W'(W_ROUTE + i / 4))
                            rd_val[8*(i%4) +: 8] = route_q[i];
                    end
                end
            endcase
        end
    end

    // Register the read data; zero when no read was issued
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (do_rd)
            bus_rdata <= rd_val;
        else
            bus_rdata <= '0;
    end
endmodule

// File: rtl/gpio_route_ctrl.sv
// Module: top of the GPIO controller with routed interrupts. It ties the
// register file, the pin synchroniser, the trigger decoder and the
// interrupt router together. The interrupt outputs are combinational from
// registered state. Assumes 1 <= NLINES <= 32, 1 <= NOUT <= 8, ADDR_W >= 7.
module gpio_route_ctrl #(
    parameter int NLINES = 32,
    parameter int NOUT   = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic [NOUT-1:0]   irq_out
);
    logic [NLINES-1:0]   pin_s;
    logic [NLINES-1:0]   pin_prev;
    logic [NLINES-1:0]   out_q;
    logic [NLINES-1:0]   dir_q;
    logic [NLINES-1:0]   mask_q;
    logic [NLINES-1:0]   pol_q;
    logic [NLINES-1:0]   edge_q;
    logic [NLINES*8-1:0] route_flat;
    logic [NLINES-1:0]   hit;

    gpio_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_lvl    (pin_s),
        .out_q      (out_q),
        .dir_q      (dir_q),
        .mask_q     (mask_q),
        .pol_q      (pol_q),
        .edge_q     (edge_q),
        .route_flat (route_flat)
    );

    gpio_sync #(.W(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (pin_s),
        .q_prev (pin_prev)
    );

    gpio_trigger #(.W(NLINES)) u_trig (
        .lvl      (pin_s),
        .lvl_prev (pin_prev),
        .polar    (pol_q),
        .edgesel  (edge_q),
        .hit      (hit)
    );

    gpio_router #(.NLINES(NLINES), .NOUT(NOUT)) u_route (
        .hit    (hit),
        .enable (mask_q),
        .route  (route_flat),
        .irq    (irq_out)
    );

    assign pin_oe  = dir_q;
    assign pin_out = out_q & dir_q;
endmodule

// File: rtl/gpio_route_ctrl_chk.sv
// Module: assertion checker for gpio_route_ctrl, attached through bind.
// It observes ports and internal register state of the top.
module gpio_route_ctrl_chk
    import gpio_route_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int NOUT   = 4,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NLINES-1:0]   pin_in,
    input logic [NLINES-1:0]   pin_oe,
    input logic [NOUT-1:0]     irq_out,
    input logic [NLINES-1:0]   pin_s,
    input logic [NLINES-1:0]   mask_q,
    input logic [NLINES*8-1:0] route_flat
);
    logic [NOUT-1:0] src_any;

    // Collect which wires have at least one enabled line routed to them
    always_comb begin
        src_any = '0;
        for (int o = 0; o < NOUT; o++)
            for (int i = 0; i < NLINES; i++)
                if (mask_q[i] && route_flat[8*i +: 8] == 8'(o))
                    src_any[o] = 1'b1;
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[o] |-> src_any[o]); // R9
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> pin_s == $past(pin_in, 2)); // R5

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == ADDR_W'(OFF_DIR))
        |=> pin_oe == $past(bus_wdata[NLINES-1:0])); // R4

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_wr) |=> bus_rdata == 32'h0); // R2
endmodule

bind gpio_route_ctrl gpio_route_ctrl_chk #(
    .NLINES(NLINES), .NOUT(NOUT), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_in     (pin_in),
    .pin_oe     (pin_oe),
    .irq_out    (irq_out),
    .pin_s      (pin_s),
    .mask_q     (mask_q),
    .route_flat (route_flat)
);

// File: tb/test_gpio_route_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios for gpio_route_ctrl, with 24 lines and 4 wires.
module test_gpio_route_ctrl;
    localparam int NL = 24;
    localparam int NO = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic [NO-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_route_ctrl #(.NLINES(NL), .NOUT(NO), .ADDR_W(AW)) i_gpio_route_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        step();
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", 32'(irq_out), 0);
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 out", 32'(pin_out), 0);
        rd(8'h0C, v); chk("R1 mask", v, 0);
        rd(8'h20, v); chk("R1 route", v, 32'hFFFF_FFFF);
        step(); chk("R2 idle zero", bus_rdata, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h04, 32'hFFAB_CDEF);
        rd(8'h04, v); chk("R11 upper bits", v, 32'h00AB_CDEF);
        wr(8'h08, 32'h0000_FF00);
        chk("R4 oe", 32'(pin_oe), 32'h0000_FF00);
        chk("R4 out", 32'(pin_out), 32'h0000_CD00);
        wr(8'h18, 32'h1234_5678);
        rd(8'h18, v); chk("R3 spare", v, 32'h0034_5678);
        chk("R3 spare no pin effect", 32'(pin_out), 32'h0000_CD00);
        rd(8'h1C, v); chk("R2 unmapped", v, 0);
        rd(8'h05, v); chk("R2 misaligned", v, 0);
        wr(8'h38, 32'h0102_0304);
        rd(8'h38, v); chk("R11 route beyond lines", v, 0);
        wr(8'h24, 32'hAA55_0102);
        rd(8'h24, v); chk("R3 route word1", v, 32'hAA55_0102);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        pin_in = 24'h5A5A5A;
        rd(8'h00, v);
        rd(8'h00, v); chk("R5 still old", v, 0);
        rd(8'h00, v); chk("R5 new value", v, 32'h005A_5A5A);
        pin_in = '0;
        step(); step(); step();
    endtask

    task automatic t_level();
        wr(8'h24, 32'hFFFF_02FF);       // line 5 -> wire 2
        wr(8'h0C, 32'h20);
        chk("R6 level low", 32'(irq_out), 32'h4);
        pin_in[5] = 1'b1;
        step(); chk("R6 low held in sync", 32'(irq_out), 32'h4);
        step(); chk("R6 low ends", 32'(irq_out), 0);
        wr(8'h10, 32'h20);
        chk("R6 level high", 32'(irq_out), 32'h4);
        pin_in[5] = 1'b0;
        step(); step(); chk("R6 high ends", 32'(irq_out), 0);
        wr(8'h0C, 32'h0);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_edges();
        wr(8'h20, 32'h01FF_FFFF);       // line 3 -> wire 1
        wr(8'h10, 32'h08);
        wr(8'h14, 32'h08);
        wr(8'h0C, 32'h08);
        chk("R7 rise idle", 32'(irq_out), 0);
        pin_in[3] = 1'b1;
        step(); chk("R7 rise not yet", 32'(irq_out), 0);
        step(); chk("R7 rise pulse", 32'(irq_out), 32'h2);
        step(); chk("R7 rise one cycle", 32'(irq_out), 0);
        wr(8'h10, 32'h0);               // falling
        pin_in[3] = 1'b0;
        step(); chk("R7 fall not yet", 32'(irq_out), 0);
        step(); chk("R7 fall pulse", 32'(irq_out), 32'h2);
        step(); chk("R7 fall one cycle", 32'(irq_out), 0);
    endtask

    task automatic t_race();
        wr(8'h10, 32'h08);              // back to rising
        pin_in[3] = 1'b1;
        step();
        wr(8'h0C, 32'h0);               // lands with detection edge
        chk("R8 clear wins same cycle", 32'(irq_out), 0);
        step(); chk("R8 stays quiet", 32'(irq_out), 0);
        wr(8'h10, 32'h0);
        wr(8'h14, 32'h0);
        pin_in[3] = 1'b0;
        wr(8'h24, 32'hFFFF_02FF);       // line 5 low level, masked
        step(); step();
        chk("R8 masked line silent", 32'(irq_out), 0);
    endtask

    task automatic t_route();
        wr(8'h24, 32'hFF09_FFFF);       // line 5 none, line 6 -> 9
        wr(8'h0C, 32'h60);
        chk("R9 no route", 32'(irq_out), 0);
        wr(8'h24, 32'hFF00_FFFF);       // line 6 -> wire 0
        chk("R9 route to 0", 32'(irq_out), 32'h1);
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
    endtask

    task automatic t_share();
        wr(8'h28, 32'hFFFF_0303);       // lines 8,9 -> wire 3
        wr(8'h10, 32'h300);
        wr(8'h0C, 32'h300);
        chk("R10 none high", 32'(irq_out), 0);
        pin_in[8] = 1'b1;
        step(); step(); chk("R10 first line", 32'(irq_out), 32'h8);
        pin_in[8] = 1'b0; pin_in[9] = 1'b1;
        step(); chk("R10 swap same cycle", 32'(irq_out), 32'h8);
        step(); chk("R10 second line", 32'(irq_out), 32'h8);
        pin_in[9] = 1'b0;
        step(); step(); chk("R10 all low", 32'(irq_out), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_sync();
        t_level();
        t_edges();
        t_race();
        t_route();
        t_share();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-reqs actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule